// File: doc/BRIEF.md
# Two-Cycle Interrupt Acknowledge Responder

This block answers the processor's interrupt acknowledge handshake when the processor sends exactly two acknowledge strobes and expects no call opcode. On the first strobe it takes a snapshot of the unmasked request lines. It also latches the winning level reported by an external priority resolver. When the device is a master and that level has a slave attached, it puts the level's 3-bit code on the cascade lines. The data bus stays off for the whole of the first strobe.

On the second strobe the device that owns the interrupt drives one vector byte. That byte is the five programmed base bits followed by the binary level number. A master drives it when no slave sits on the acknowledged level. A slave drives it when the cascade code it sampled at the start of the second strobe matches its own identity. The priority resolver and the decoding of configuration writes live outside this block. The base bits, the master/slave setting and the slave map arrive as static inputs.

Top module: `intack_responder`

## Requirements
- R1: While reset is asserted, and after it is released, `vec_oe` and `cas_oe` are 0 and `vec_out`, `cas_out` and `frz_req` are 0. The next low `inta_n` is treated as the first strobe of a pair, including after a reset in the middle of a handshake.
- R2: In the clock cycle in which `inta_n` is first sampled low, `frz_req` captures `irq_req & ~irq_mask`. It then holds that value until the next first strobe.
- R3: During the first strobe and in the gap before the second, `vec_oe` is 0. `vec_out` reads 0 whenever `vec_oe` is 0.
- R4: For the device that owns the vector, `vec_oe` goes to 1 one cycle after the second strobe is sampled low and returns to 0 one cycle after `inta_n` is sampled high. While `vec_oe` is 1, `vec_out[7:3]` equals `vec_base` and `vec_out[2:0]` equals the acknowledged level (IR0 = 000 to IR7 = 111).
- R5: The acknowledged level is the one latched at the first strobe. Changes on `top_level`, `top_valid`, `irq_req` or `irq_mask` after that point do not change `frz_req` or the vector.
- R6: If `top_valid` is 0 when the first strobe is sampled, the acknowledged level is 7.
- R7: A master whose acknowledged level has its `slave_map` bit set asserts `cas_oe` with `cas_out` equal to the level. This runs from one cycle after the first strobe is sampled low until one cycle after the second strobe is sampled high. In every other case `cas_oe` and `cas_out` are 0, and a slave never drives them.
- R8: A master leaves `vec_oe` at 0 when the acknowledged level has a slave. A slave asserts `vec_oe` only if `cas_in` equals `slave_id` in the cycle where the second strobe is first sampled low.
- R9: Once the second strobe ends, the sequencer returns to the first-strobe state, so back-to-back handshakes each yield exactly one vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inta_n | input | 1 | Acknowledge strobe, active low, synchronous to `clk` |
| irq_req | input | 8 | Request line state |
| irq_mask | input | 8 | Mask bits, 1 = masked |
| top_valid | input | 1 | Resolver has a pending level |
| top_level | input | 3 | Highest-priority pending level from the resolver |
| vec_base | input | 5 | Programmed vector bits 7..3 |
| is_master | input | 1 | 1 = master, 0 = slave |
| slave_map | input | 8 | Master only: bit n set means a slave sits on level n |
| slave_id | input | 3 | Slave only: own cascade identity |
| cas_in | input | 3 | Cascade lines as seen by a slave |
| frz_req | output | 8 | Frozen unmasked request snapshot |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Cascade output enable |
| vec_out | output | 8 | Vector byte |
| vec_oe | output | 1 | Data bus output enable |

## Verification
A sequencer stuck in the wrong phase shows at once on `vec_oe`. It either rises during a first strobe or fails to rise on the second, and the bench sees this on the sampling point one cycle after the strobe. A level or snapshot that was latched at the wrong moment shows up later. It appears as wrong low bits of the vector on the second strobe, or as a changed `frz_req` in the gap. The bench therefore changes the resolver inputs between the two strobes. A wrong ownership decision shows as an enabled bus or cascade where the other device should drive, and is visible within the same handshake.

// File: rtl/intack_pkg.sv
package intack_pkg;

  // Handshake phase; order is the sequence the strobes walk through
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // waiting for the first strobe
    PH_ACK1 = 2'd1,  // first strobe low
    PH_GAP  = 2'd2,  // between the strobes
    PH_ACK2 = 2'd3   // second strobe low
  } ack_ph_t;

endpackage

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inta_n,
  output ack_ph_t phase,
  output logic    freeze_en,
  output logic    sel_en
);

  ack_ph_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (!inta_n) ph_d = PH_ACK1;
      PH_ACK1: if (inta_n)  ph_d = PH_GAP;
      PH_GAP:  if (!inta_n) ph_d = PH_ACK2;
      PH_ACK2: if (inta_n)  ph_d = PH_IDLE;
      default:              ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase     = ph_q;
  assign freeze_en = (ph_q == PH_IDLE) && !inta_n;
  assign sel_en    = (ph_q == PH_GAP)  && !inta_n;

endmodule

// File: rtl/intack_freeze.sv
module intack_freeze #(
  parameter int NLVL = 8,
  localparam int LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze_en,
  input  logic            sel_en,
  input  logic [NLVL-1:0] irq_req,
  input  logic [NLVL-1:0] irq_mask,
  input  logic            top_valid,
  input  logic [LVLW-1:0] top_level,
  input  logic [LVLW-1:0] cas_in,
  input  logic [LVLW-1:0] slave_id,
  output logic [NLVL-1:0] frz_req,
  output logic [LVLW-1:0] lvl_q,
  output logic            sel_q
);

  localparam logic [LVLW-1:0] SPUR_LVL = LVLW'(NLVL - 1);

  logic [NLVL-1:0] frz_d;
  logic [LVLW-1:0] lvl_d;
  logic            sel_d;

  always_comb begin
    frz_d = frz_req;
    lvl_d = lvl_q;
    sel_d = sel_q;
    if (freeze_en) begin
      frz_d = irq_req & ~irq_mask;
      lvl_d = top_valid ? top_level : SPUR_LVL;
    end
    if (sel_en) sel_d = (cas_in == slave_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_req <= '0;
      lvl_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      frz_req <= frz_d;
      lvl_q   <= lvl_d;
      sel_q   <= sel_d;
    end
  end

endmodule

// File: rtl/intack_drive.sv
module intack_drive
  import intack_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int VECW = 8,
  localparam int LVLW  = $clog2(NLVL),
  localparam int BASEW = VECW - LVLW
) (
  input  ack_ph_t          phase,
  input  logic [LVLW-1:0]  lvl_q,
  input  logic             sel_q,
  input  logic             is_master,
  input  logic [NLVL-1:0]  slave_map,
  input  logic [BASEW-1:0] vec_base,
  output logic [LVLW-1:0]  cas_out,
  output logic             cas_oe,
  output logic [VECW-1:0]  vec_out,
  output logic             vec_oe
);

  logic lvl_has_slave;
  logic own_vec;
  logic in_hs;

  always_comb begin
    lvl_has_slave = slave_map[lvl_q];
    own_vec       = is_master ? !lvl_has_slave : sel_q;
    in_hs         = (phase != PH_IDLE);
    cas_oe        = is_master && lvl_has_slave && in_hs;
    cas_out       = cas_oe ? lvl_q : '0;
    vec_oe        = (phase == PH_ACK2) && own_vec;
    vec_out       = vec_oe ? {vec_base, lvl_q} : '0;
  end

endmodule

// File: rtl/intack_responder.sv
module intack_responder
  import intack_pkg::*;
#(
  parameter int NLVL = 8,
  parameter int VECW = 8,
  localparam int LVLW  = $clog2(NLVL),
  localparam int BASEW = VECW - LVLW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inta_n,
  input  logic [NLVL-1:0]  irq_req,
  input  logic [NLVL-1:0]  irq_mask,
  input  logic             top_valid,
  input  logic [LVLW-1:0]  top_level,
  input  logic [BASEW-1:0] vec_base,
  input  logic             is_master,
  input  logic [NLVL-1:0]  slave_map,
  input  logic [LVLW-1:0]  slave_id,
  input  logic [LVLW-1:0]  cas_in,
  output logic [NLVL-1:0]  frz_req,
  output logic [LVLW-1:0]  cas_out,
  output logic             cas_oe,
  output logic [VECW-1:0]  vec_out,
  output logic             vec_oe
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  ack_ph_t         phase;
  logic            freeze_en;
  logic            sel_en;
  logic [LVLW-1:0] lvl_q;
  logic            sel_q;

  intack_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .inta_n    (inta_n),
    .phase     (phase),
    .freeze_en (freeze_en),
    .sel_en    (sel_en)
  );

  intack_freeze #(.NLVL(NLVL)) u_frz (
    .clk       (clk),
    .rst_n     (rst_q),
    .freeze_en (freeze_en),
    .sel_en    (sel_en),
    .irq_req   (irq_req),
    .irq_mask  (irq_mask),
    .top_valid (top_valid),
    .top_level (top_level),
    .cas_in    (cas_in),
    .slave_id  (slave_id),
    .frz_req   (frz_req),
    .lvl_q     (lvl_q),
    .sel_q     (sel_q)
  );

  intack_drive #(.NLVL(NLVL), .VECW(VECW)) u_drv (
    .phase     (phase),
    .lvl_q     (lvl_q),
    .sel_q     (sel_q),
    .is_master (is_master),
    .slave_map (slave_map),
    .vec_base  (vec_base),
    .cas_out   (cas_out),
    .cas_oe    (cas_oe),
    .vec_out   (vec_out),
    .vec_oe    (vec_oe)
  );

endmodule

// File: rtl/intack_responder_chk.sv
module intack_responder_chk #(
  parameter int NLVL = 8,
  parameter int VECW = 8,
  localparam int LVLW  = $clog2(NLVL),
  localparam int BASEW = VECW - LVLW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inta_n,
  input logic             is_master,
  input logic [BASEW-1:0] vec_base,
  input logic [NLVL-1:0]  frz_req,
  input logic             cas_oe,
  input logic [VECW-1:0]  vec_out,
  input logic             vec_oe
);

  // R2
  frz_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frz_req) |-> !$past(inta_n));

  // R4
  vec_oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe) |-> !$past(inta_n));

  // R4
  vec_oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vec_oe) |-> $past(inta_n));

  // R4
  vec_base_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_out[VECW-1:LVLW] == vec_base));

  // R7
  cas_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_oe |-> is_master);

  // R8
  master_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && cas_oe) |-> !vec_oe);

endmodule

bind intack_responder intack_responder_chk #(.NLVL(NLVL), .VECW(VECW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .inta_n    (inta_n),
  .is_master (is_master),
  .vec_base  (vec_base),
  .frz_req   (frz_req),
  .cas_oe    (cas_oe),
  .vec_out   (vec_out),
  .vec_oe    (vec_oe)
);

// File: tb/intack_responder_bench.sv
`timescale 1ns/1ps
module intack_responder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inta_n;
  logic [7:0] irq_req, irq_mask, slave_map, frz_req, vec_out;
  logic       top_valid, is_master, cas_oe, vec_oe;
  logic [2:0] top_level, slave_id, cas_in, cas_out;
  logic [4:0] vec_base;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intack_responder u_intack_responder (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .irq_req(irq_req),
    .irq_mask(irq_mask), .top_valid(top_valid), .top_level(top_level),
    .vec_base(vec_base), .is_master(is_master), .slave_map(slave_map),
    .slave_id(slave_id), .cas_in(cas_in), .frz_req(frz_req),
    .cas_out(cas_out), .cas_oe(cas_oe), .vec_out(vec_out), .vec_oe(vec_oe)
  );

  // {master, slave_map, slave_id, cas_in, base, valid, level, exp_oe, exp_vec, exp_cas_oe}
  localparam logic [33:0] VECS [8] = '{
    {1'b1, 8'h00, 3'd0, 3'd0, 5'b10101, 1'b1, 3'd3, 1'b1, 8'hAB, 1'b0},
    {1'b1, 8'h00, 3'd0, 3'd0, 5'b00001, 1'b1, 3'd0, 1'b1, 8'h08, 1'b0},
    {1'b1, 8'h00, 3'd0, 3'd0, 5'b11111, 1'b1, 3'd7, 1'b1, 8'hFF, 1'b0},
    {1'b1, 8'h04, 3'd0, 3'd0, 5'b01000, 1'b1, 3'd2, 1'b0, 8'h00, 1'b1},
    {1'b1, 8'h04, 3'd0, 3'd0, 5'b01000, 1'b1, 3'd5, 1'b1, 8'h45, 1'b0},
    {1'b0, 8'h00, 3'd3, 3'd3, 5'b10000, 1'b1, 3'd6, 1'b1, 8'h86, 1'b0},
    {1'b0, 8'h00, 3'd3, 3'd5, 5'b10000, 1'b1, 3'd6, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h00, 3'd0, 3'd0, 5'b00110, 1'b0, 3'd2, 1'b1, 8'h37, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; inta_n = 1'b1; irq_req = '0; irq_mask = '0; top_valid = 1'b0;
    top_level = '0; vec_base = '0; is_master = 1'b1; slave_map = '0;
    slave_id = '0; cas_in = '0;
    repeat (3) cyc();
    // R1 during reset
    chk(vec_oe == 0 && cas_oe == 0, "R1 oe in reset", {vec_oe, cas_oe}, 0);
    chk(frz_req == 0 && vec_out == 0 && cas_out == 0, "R1 data in reset", frz_req, 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(vec_oe == 0 && cas_oe == 0 && frz_req == 0, "R1 after release",
        {vec_oe, cas_oe, frz_req}, 0);

    // table of handshakes, back to back (R3 R4 R6 R7 R8 R9)
    for (int i = 0; i < 8; i++) begin
      logic [33:0] v;
      v = VECS[i];
      is_master = v[33]; slave_map = v[32:25]; slave_id = v[24:22];
      cas_in = 3'd0; vec_base = v[18:14]; top_valid = v[13]; top_level = v[12:10];
      inta_n = 1'b0;
      cyc();
      chk(vec_oe == 0 && vec_out == 0, "R3 first strobe bus off", vec_out, 0);
      chk(cas_oe == v[0], "R7 cas_oe first strobe", cas_oe, v[0]);
      chk(cas_out == (v[0] ? v[12:10] : 3'd0), "R7 cas code", cas_out,
          v[0] ? v[12:10] : 3'd0);
      inta_n = 1'b1;
      top_level = ~v[12:10]; top_valid = 1'b1;  // R5 late resolver change ignored
      cas_in = v[21:19];
      cyc();
      chk(vec_oe == 0, "R3 gap bus off", vec_oe, 0);
      inta_n = 1'b0;
      cyc();
      chk(vec_oe == v[9], "R8 owner enable", vec_oe, v[9]);
      chk(vec_out == v[8:1], "R4 R6 vector byte", vec_out, v[8:1]);
      chk(cas_oe == v[0], "R7 cas_oe second strobe", cas_oe, v[0]);
      inta_n = 1'b1;
      cyc();
      chk(vec_oe == 0 && cas_oe == 0, "R9 release after pair", {vec_oe, cas_oe}, 0);
    end

    // R2 R5: snapshot and level held across the handshake
    is_master = 1'b1; slave_map = '0; vec_base = 5'b00010;
    irq_req = 8'hF0; irq_mask = 8'h30; top_valid = 1'b1; top_level = 3'd4;
    inta_n = 1'b0;
    cyc();
    chk(frz_req == 8'hC0, "R2 snapshot", frz_req, 8'hC0);
    inta_n = 1'b1; irq_req = 8'h00; irq_mask = 8'hFF; top_level = 3'd1; top_valid = 1'b0;
    cyc();
    chk(frz_req == 8'hC0, "R5 snapshot held in gap", frz_req, 8'hC0);
    inta_n = 1'b0;
    cyc();
    chk(vec_out == 8'h14 && vec_oe, "R5 frozen level in vector", vec_out, 8'h14);
    inta_n = 1'b1;
    cyc();
    chk(frz_req == 8'hC0, "R2 held after pair", frz_req, 8'hC0);
    irq_req = 8'h0F; irq_mask = 8'h00;
    inta_n = 1'b0;
    cyc();
    chk(frz_req == 8'h0F, "R9 R2 next first strobe", frz_req, 8'h0F);
    chk(vec_oe == 0, "R9 next strobe is first", vec_oe, 0);

    // R1: reset in the middle of a handshake
    rst_n = 1'b0;
    cyc();
    chk(vec_oe == 0 && frz_req == 0, "R1 mid-handshake reset", frz_req, 0);
    inta_n = 1'b1; rst_n = 1'b1;
    repeat (4) cyc();
    inta_n = 1'b0;
    cyc();
    chk(vec_oe == 0, "R1 first strobe after reset", vec_oe, 0);
    inta_n = 1'b1;
    cyc();
    inta_n = 1'b0;
    cyc();
    chk(vec_oe == 1'b1, "R1 pair completes after reset", vec_oe, 1);
    inta_n = 1'b1;
    repeat (2) cyc();

    finish_run();
  end

endmodule